// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Interface

This block holds the interrupt logic of several I/O device interfaces linked in a chain. Each interface cell has a control register that holds a vector address and a per-device enable bit. It also has a request flag, which the device's ready event sets. Every cell whose request flag and enable bit are both set pulls on one shared request line to the processor. The processor answers with an acknowledge at the head of the chain. That acknowledge ripples from cell to cell and stops at the first cell that is actively requesting.

The winning cell places its vector address and its device information bits on a shared return bus. Every other cell drives zeros, so the bus is the OR of all cells. The winner clears its request at the clock edge on which it holds the acknowledge. Position in the chain therefore sets priority: index 0 is nearest the processor and wins over every later index. The acknowledge that leaves the far end of the chain shows that no enabled cell claimed it.

Top module: `irq_chain`

## Requirements
- R1: After synchronous reset every request flag, enable bit and vector is zero. `ireq` is low, `vec_bus` is zero and `iack_out` equals `iack_in`.
- R2: A pulse on `ctrl_wr[i]` loads cell i at the next edge. The enable bit is `ctrl_wdata[0]` and the vector is `ctrl_wdata` with bit 0 forced to zero. Writing 0x1F1 gives vector 0x1F0 with interrupts on, and writing 0 turns them off.
- R3: A pulse on `dev_ready[i]` sets cell i's request flag at the next edge. If the cell is enabled, `ireq` is high from that edge on.
- R4: A cell whose enable bit is zero never raises `ireq`, even when its request flag is set.
- R5: The acknowledge is taken by the lowest-indexed cell that is both requesting and enabled. No cell past that one sees it.
- R6: While a cell holds the acknowledge, `vec_bus` carries {that cell's `dev_info` field, its vector}, with the vector in the low `CTRL_W` bits. At every other time `vec_bus` is zero.
- R7: A cell's request flag clears at the edge on which it holds the acknowledge. If `dev_ready` for that cell pulses in the same cycle, the flag stays set.
- R8: A disabled cell with a latched request passes the acknowledge on and keeps its request. Enabling it later makes it raise `ireq`.
- R9: `iack_out` is high only when `iack_in` is high and no cell is both enabled and requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | N_DEV | Per-cell control register write strobe |
| ctrl_wdata | input | CTRL_W | Control write data: bit 0 is the enable, the rest is the vector |
| dev_ready | input | N_DEV | Per-cell device ready pulse |
| dev_info | input | N_DEV*INFO_W | Information bits per cell; cell i uses bits [i*INFO_W +: INFO_W] |
| iack_in | input | 1 | Acknowledge from the processor into cell 0 |
| ireq | output | 1 | Shared interrupt request (OR of enabled requests) |
| iack_out | output | 1 | Acknowledge leaving the last cell, unclaimed |
| vec_bus | output | INFO_W+CTRL_W | OR-combined vector and information return bus |

## Verification
On every cycle, the assertions check several local rules. A ready pulse must set its cell's flag, and taking the acknowledge must clear it. A masked request must persist. At most one cell may own the acknowledge. The return bus must stay quiet when no acknowledge is present, and the chain end must never show an acknowledge the head did not get.

Priority order among several pending cells, the exact vector and information value returned, and the read-back of a write through the acknowledge path need the bench's scenarios and its reference model. The same holds for a ready pulse that coincides with a take, and for re-enabling a masked cell.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // Position of the enable bit inside the control word
    localparam int EN_BIT = 0;

    // Condition of one cell, derived from its two flags
    typedef enum logic [1:0] {
        CELL_IDLE   = 2'd0,
        CELL_MASKED = 2'd1,
        CELL_ARMED  = 2'd2
    } cell_state_e;

    function automatic cell_state_e cell_state(input logic pending, input logic enabled);
        if (!pending)
            return CELL_IDLE;
        else if (!enabled)
            return CELL_MASKED;
        else
            return CELL_ARMED;
    endfunction

endpackage

// File: rtl/irq_cell.sv
module irq_cell
    import irq_chain_pkg::*;
#(
    parameter int CTRL_W = 12,
    parameter int INFO_W = 4,
    localparam int BUS_W = INFO_W + CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              ready,
    input  logic [INFO_W-1:0] info,
    input  logic              ack_in,
    output logic              ack_out,
    output logic              req_line,
    output logic              take,
    output logic [BUS_W-1:0]  drive,
    output logic              pend_q,
    output logic              en_q
);

    typedef struct packed {
        logic [CTRL_W-1:0] vector;
        logic              enable;
    } ctrl_t;

    ctrl_t       ctrl;
    cell_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.vector         <= wdata;
            ctrl.vector[EN_BIT] <= 1'b0;
            ctrl.enable         <= wdata[EN_BIT];
        end
    end

    always_comb state = cell_state(pend_q, ctrl.enable);

    assign take     = ack_in && (state == CELL_ARMED);
    assign ack_out  = ack_in && (state != CELL_ARMED);
    assign req_line = (state == CELL_ARMED);
    assign drive    = take ? {info, ctrl.vector} : '0;
    assign en_q     = ctrl.enable;

    // A new ready event wins over the clear from a taken acknowledge
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (ready)
            pend_q <= 1'b1;
        else if (take)
            pend_q <= 1'b0;
    end

endmodule

// File: rtl/or_merge.sv
module or_merge #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic [N-1:0][W-1:0] din,
    output logic [W-1:0]        dout
);

    logic [N:0][W-1:0] acc;

    assign acc[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_acc
        assign acc[i+1] = acc[i] | din[i];
    end
    assign dout = acc[N];

endmodule

// File: rtl/irq_chain.sv
module irq_chain #(
    parameter int N_DEV  = 4,
    parameter int CTRL_W = 12,
    parameter int INFO_W = 4,
    localparam int BUS_W = INFO_W + CTRL_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_DEV-1:0]        ctrl_wr,
    input  logic [CTRL_W-1:0]       ctrl_wdata,
    input  logic [N_DEV-1:0]        dev_ready,
    input  logic [N_DEV*INFO_W-1:0] dev_info,
    input  logic                    iack_in,
    output logic                    ireq,
    output logic                    iack_out,
    output logic [BUS_W-1:0]        vec_bus
);

    logic [N_DEV:0]                 ack_link;
    logic [N_DEV-1:0]               req_lines;
    logic [N_DEV-1:0]               take_vec;
    logic [N_DEV-1:0]               pend_vec;
    logic [N_DEV-1:0]               en_vec;
    logic [N_DEV-1:0][BUS_W-1:0]    drives;

    assign ack_link[0] = iack_in;

    for (genvar i = 0; i < N_DEV; i++) begin : g_cell
        irq_cell #(
            .CTRL_W(CTRL_W),
            .INFO_W(INFO_W)
        ) u_cell (
            .clk      (clk),
            .rst      (rst),
            .wr       (ctrl_wr[i]),
            .wdata    (ctrl_wdata),
            .ready    (dev_ready[i]),
            .info     (dev_info[i*INFO_W +: INFO_W]),
            .ack_in   (ack_link[i]),
            .ack_out  (ack_link[i+1]),
            .req_line (req_lines[i]),
            .take     (take_vec[i]),
            .drive    (drives[i]),
            .pend_q   (pend_vec[i]),
            .en_q     (en_vec[i])
        );
    end

    or_merge #(
        .N(N_DEV),
        .W(BUS_W)
    ) u_bus (
        .din  (drives),
        .dout (vec_bus)
    );

    assign ireq     = |req_lines;
    assign iack_out = ack_link[N_DEV];

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int N_DEV = 4,
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [N_DEV-1:0] dev_ready,
    input logic             iack_in,
    input logic             iack_out,
    input logic             ireq,
    input logic [BUS_W-1:0] vec_bus,
    input logic [N_DEV-1:0] pend_vec,
    input logic [N_DEV-1:0] en_vec,
    input logic [N_DEV-1:0] take_vec
);

    assert_one_owner_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_vec));

    assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (vec_bus != '0) |-> iack_in);

    assert_end_ack_R9: assert property (@(posedge clk) disable iff (rst)
        iack_out |-> iack_in);

    assert_idle_passes_R9: assert property (@(posedge clk) disable iff (rst)
        !ireq |-> (iack_out == iack_in));

    for (genvar i = 0; i < N_DEV; i++) begin : g_cell_chk
        assert_ready_sets_R3: assert property (@(posedge clk) disable iff (rst)
            dev_ready[i] |=> pend_vec[i]);

        assert_take_clears_R7: assert property (@(posedge clk) disable iff (rst)
            (take_vec[i] && !dev_ready[i]) |=> !pend_vec[i]);

        assert_masked_holds_R8: assert property (@(posedge clk) disable iff (rst)
            (pend_vec[i] && !en_vec[i]) |=> pend_vec[i]);

        assert_masked_silent_R4: assert property (@(posedge clk) disable iff (rst)
            !en_vec[i] |-> !take_vec[i]);
    end

endmodule

bind irq_chain irq_chain_chk #(
    .N_DEV(N_DEV),
    .BUS_W(BUS_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dev_ready(dev_ready),
    .iack_in  (iack_in),
    .iack_out (iack_out),
    .ireq     (ireq),
    .vec_bus  (vec_bus),
    .pend_vec (pend_vec),
    .en_vec   (en_vec),
    .take_vec (take_vec)
);

// File: tb/irq_chain_test.sv
module irq_chain_test;

    localparam int N      = 4;
    localparam int CW     = 12;
    localparam int IW     = 4;
    localparam int BW     = IW + CW;

    logic              clk = 1'b0;
    logic              rst;
    logic [N-1:0]      ctrl_wr;
    logic [CW-1:0]     ctrl_wdata;
    logic [N-1:0]      dev_ready;
    logic [N*IW-1:0]   dev_info;
    logic              iack_in;
    logic              ireq;
    logic              iack_out;
    logic [BW-1:0]     vec_bus;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Reference model state
    bit          m_req [N];
    bit          m_en  [N];
    int unsigned m_vec [N];

    always #2 clk = ~clk;

    irq_chain #(.N_DEV(N), .CTRL_W(CW), .INFO_W(IW)) uut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .dev_ready(dev_ready), .dev_info(dev_info), .iack_in(iack_in),
        .ireq(ireq), .iack_out(iack_out), .vec_bus(vec_bus)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: compare outputs against the model, then advance the model at the edge
    task automatic step(input string tag);
        int owner;
        bit a;
        bit any;
        int exp_bus;
        #1;
        a = iack_in; owner = -1; any = 0;
        for (int i = 0; i < N; i++) begin
            if (m_req[i] && m_en[i]) begin
                any = 1;
                if (a) begin owner = i; a = 0; end
            end
        end
        exp_bus = (owner < 0) ? 0 :
                  ((((dev_info >> (owner*IW)) & ((1 << IW) - 1)) << CW) | m_vec[owner]);
        check(tag, "ireq", ireq, any);
        check(tag, "iack_out", iack_out, a);
        check(tag, "vec_bus", vec_bus, exp_bus);
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                m_req[i] = 0; m_en[i] = 0; m_vec[i] = 0;
            end else begin
                if (ctrl_wr[i]) begin
                    m_en[i]  = ctrl_wdata[0];
                    m_vec[i] = ctrl_wdata & ~1;
                end
                if (dev_ready[i]) m_req[i] = 1;
                else if (owner == i) m_req[i] = 0;
            end
        end
        @(negedge clk);
        ctrl_wr = '0; dev_ready = '0; iack_in = 1'b0;
    endtask

    task automatic write_ctrl(input int dev, input int val, input string tag);
        ctrl_wr[dev] = 1'b1; ctrl_wdata = val[CW-1:0];
        step(tag);
    endtask

    task automatic ready(input int dev, input string tag);
        dev_ready[dev] = 1'b1;
        step(tag);
    endtask

    task automatic ack(input string tag);
        iack_in = 1'b1;
        step(tag);
    endtask

    initial begin
        #100000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctrl_wr = '0; ctrl_wdata = '0; dev_ready = '0; iack_in = 1'b0;
        for (int i = 0; i < N; i++) dev_info[i*IW +: IW] = IW'(i + 5);
        for (int i = 0; i < N; i++) begin m_req[i] = 0; m_en[i] = 0; m_vec[i] = 0; end
        @(negedge clk);
        step("R1"); step("R1");
        rst = 1'b0;
        // R1: acknowledge straight through an empty chain
        ack("R1");

        // R2/R3/R6: program cell 1 with 0x1F1, raise request, read vector back
        write_ctrl(1, 'h1F1, "R2");
        ready(1, "R3");
        step("R3");
        ack("R6");
        step("R7");

        // R4/R8: disabled cell 0 latches a request but stays silent and passes the ack
        ready(0, "R4");
        step("R4");
        ack("R8");
        write_ctrl(0, 'h2A5, "R8");
        step("R8");

        // R5: cells 0 and 2 both pending; cell 0 wins first, then cell 2
        write_ctrl(2, 'h0C3, "R5");
        ready(2, "R5");
        ack("R5");
        ack("R5");
        step("R5");

        // R7: ready pulse coinciding with the take keeps the request
        ready(3, "R7");
        write_ctrl(3, 'hFFF, "R7");
        dev_ready[3] = 1'b1; iack_in = 1'b1;
        step("R7");
        ack("R7");
        step("R7");

        // R2: writing zero disables; pending request is masked, ack goes through
        ready(1, "R2");
        write_ctrl(1, 0, "R2");
        ack("R9");
        write_ctrl(1, 'h1F1, "R8");
        ack("R8");
        ack("R9");

        // R1: reset in the middle clears everything
        ready(2, "R1");
        rst = 1'b1; step("R1");
        rst = 1'b0; ack("R1");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule